// File: doc/BRIEF.md
# CAN Bit Timing Generator

The block derives CAN bit framing from the system clock. A programmable prescaler makes the time quantum. Each bit is laid out as one synchronization quantum, then a first timing segment, then a second timing segment. The block gives a one-cycle sample strike at the end of the first segment and a one-cycle bit-edge strobe at the end of the last quantum, which the transmitter uses. It also gives the received bit value. That value is taken from a single sample, or from a 2-of-3 majority vote when triple sampling is enabled.

The prescaler, the two segment lengths and the sampling mode sit in one timing register. Every length field is stored as its length minus one. The host changes the register through a request/acknowledge handshake. It raises a configuration request. The block grants the request only at a bit boundary, so a bit in progress is never cut short. Once granted, the block parks its counters and sets its configuration-enable status. Writes take effect only while that status is high. When the host drops the request, the status clears and timing restarts at the sync segment with the new values.

While the bus is idle, a recessive-to-dominant edge on the received line hard-synchronizes the block: the quantum count restarts at the sync segment.

Top module: `canBitTimer`

## Requirements
- R1: One time quantum lasts (prescaler field + 1) clock cycles. The prescaler field is bits [7:0] of the timing register.
- R2: One bit lasts 1 + (tseg1 field + 1) + (tseg2 field + 1) quanta. The tseg1 field is bits [11:8] and the tseg2 field is bits [14:12]. `bitEdge` pulses for one cycle at the end of the last quantum of each bit.
- R3: `sampleStrike` pulses for one cycle at the end of quantum number tseg1+1, counting the sync quantum as number 0. It never coincides with `bitEdge`.
- R4: With bit [15] clear (single sampling), `rxBit` takes the value of `rxIn` at the sample-strike clock edge. Otherwise `rxBit` holds its value.
- R5: With bit [15] set (triple sampling), `rxBit` takes the majority of three samples of `rxIn`: the one at the end of the sample quantum and the ones at the ends of the two quanta before it.
- R6: While `cfgReq` is high and `cfgAck` is low, `cfgAck` rises only at the clock edge that ends a bit.
- R7: A write (`wrEn` high) while `cfgAck` is low is ignored, and `rdData` keeps its old value.
- R8: A write while `cfgAck` is high loads `wrData` into the timing register. The new value is visible on `rdData` the next cycle.
- R9: With `cfgAck` high and `cfgReq` low, `cfgAck` clears at the next edge. Counting then restarts at the sync segment, so the first sample strike comes (prescaler+1)*(tseg1+2) cycles later.
- R10: With `cfgAck` low and `busIdle` high, a 1-to-0 change of `rxIn` between successive clock edges restarts the quantum count at the sync segment. The first sample strike then comes (prescaler+1)*(tseg1+2) cycles after that edge. No strobe or sample is taken at the edge itself.
- R11: After reset, `cfgAck`, `sampleStrike` and `bitEdge` are 0, `rxBit` is 1, and `rdData` is 16'h1300 (prescaler 0, tseg1 3, tseg2 1, single sampling).
- R12: While in configuration mode, neither `sampleStrike` nor `bitEdge` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgReq | input | 1 | Configuration-change request from the host |
| cfgAck | output | 1 | Configuration mode entered; timing writes allowed |
| wrEn | input | 1 | Timing register write strobe |
| wrData | input | 16 | Timing register write value |
| rdData | output | 16 | Current timing register |
| rxIn | input | 1 | Received bus line, already synchronized (1 = recessive) |
| busIdle | input | 1 | Bus idle; enables hard synchronization |
| sampleStrike | output | 1 | One-cycle pulse at the sample point |
| bitEdge | output | 1 | One-cycle pulse at the end of each bit |
| rxBit | output | 1 | Sampled received bit |

## Verification
The hardest cases to reach from the ports are the ones where two events meet in the same cycle. A configuration request can line up with the edge that ends a bit. A hard-sync edge can land in the middle of a quantum, or on the very quantum where a sample or boundary would have fired. The stimulus reaches these cases by driving the received line from a pseudo-random source while the bus is idle, which produces many falling edges at scattered phases. It also raises and drops configuration requests at arbitrary points in a bit. A cycle-accurate behavioural model in the bench predicts every output on every cycle, so each of these collisions is checked when it happens.

// File: rtl/canBtPkg.sv
package canBtPkg;

  // strobes from the control section to the counting datapath
  typedef struct packed {
    logic hold;      // configuration mode: park counters, no strobes
    logic hardSync;  // restart at the sync quantum this cycle
  } btCtlT;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/canBtCtl.sv
module canBtCtl
  import canBtPkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int T1_W   = 4,
  parameter int T2_W   = 3,
  parameter int RST_PRE = 0,
  parameter int RST_T1  = 3,
  parameter int RST_T2  = 1,
  localparam int REG_W = PRE_W + T1_W + T2_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgReq,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             rxIn,
  input  logic             busIdle,
  input  logic             endOfBit,
  output logic             cfgAck,
  output logic [REG_W-1:0] timingReg,
  output btCtlT            ctl
);

  localparam logic [REG_W-1:0] RST_VAL =
    {1'b0, T2_W'(RST_T2), T1_W'(RST_T1), PRE_W'(RST_PRE)};

  logic prevRx;
  logic fallSeen;

  assign fallSeen     = prevRx & ~rxIn;
  assign ctl.hold     = cfgAck;
  assign ctl.hardSync = ~cfgAck & busIdle & fallSeen;

  // previous line level for edge detection (recessive after reset)
  always_ff @(posedge clk) begin
    if (!rstN) prevRx <= 1'b1;
    else       prevRx <= rxIn;
  end

  // request/acknowledge handshake: grant only at a bit boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgAck <= 1'b0;
    end else if (!cfgAck) begin
      if (cfgReq && endOfBit) cfgAck <= 1'b1;
    end else if (!cfgReq) begin
      cfgAck <= 1'b0;
    end
  end

  // timing register, writable only in configuration mode
  always_ff @(posedge clk) begin
    if (!rstN)                timingReg <= RST_VAL;
    else if (cfgAck && wrEn)  timingReg <= wrData;
  end

  AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgAck) |-> $past(endOfBit) && $past(cfgReq));                 // R6
  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgAck && wrEn) |=> timingReg == $past(timingReg));                // R7
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAck && !cfgReq) |=> !cfgAck);                                    // R9

endmodule

// File: rtl/canBtDp.sv
module canBtDp
  import canBtPkg::*;
#(
  parameter int PRE_W = 8,
  parameter int T1_W  = 4,
  parameter int T2_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  btCtlT            ctl,
  input  logic [PRE_W-1:0] preField,
  input  logic [T1_W-1:0]  t1Field,
  input  logic [T2_W-1:0]  t2Field,
  input  logic             tripleEn,
  input  logic             rxIn,
  output logic             endOfBit,
  output logic             sampleStrike,
  output logic             bitEdge,
  output logic             rxBit
);

  localparam int Q_MAX = 1 + (1 << T1_W) + (1 << T2_W);
  localparam int Q_W   = $clog2(Q_MAX + 1);

  logic [PRE_W-1:0] preCnt;
  logic [Q_W-1:0]   qCnt;
  logic [Q_W-1:0]   lastQ;
  logic [Q_W-1:0]   sampQ;
  logic [1:0]       hist;
  logic             tick;
  logic             adv;
  logic             atSample;
  logic             voted;

  assign lastQ    = Q_W'(t1Field) + Q_W'(t2Field) + Q_W'(2);
  assign sampQ    = Q_W'(t1Field) + Q_W'(1);
  assign tick     = (preCnt == preField);
  assign adv      = tick & ~ctl.hold & ~ctl.hardSync;
  assign endOfBit = adv & (qCnt == lastQ);
  assign atSample = adv & (qCnt == sampQ);
  assign voted    = maj3(hist[1], hist[0], rxIn);

  // prescaler and quantum counters
  always_ff @(posedge clk) begin
    if (!rstN || ctl.hold || ctl.hardSync) begin
      preCnt <= '0;
      qCnt   <= '0;
    end else if (tick) begin
      preCnt <= '0;
      qCnt   <= (qCnt == lastQ) ? '0 : qCnt + Q_W'(1);
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  // per-quantum sample history and strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist         <= 2'b11;
      rxBit        <= 1'b1;
      sampleStrike <= 1'b0;
      bitEdge      <= 1'b0;
    end else begin
      sampleStrike <= atSample;
      bitEdge      <= endOfBit;
      if (adv) hist <= {hist[0], rxIn};
      if (atSample) rxBit <= tripleEn ? voted : rxIn;
    end
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.hold || ctl.hardSync) |=> (qCnt == '0 && preCnt == '0));        // R10
  AST_STROBE_DISJOINT: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleStrike && bitEdge));                                         // R3
  AST_Q_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.hold |-> qCnt <= lastQ);                                        // R2
  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.hold |-> preCnt <= preField);                                   // R1
  AST_QUIET_IN_CFG: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hold |=> (!sampleStrike && !bitEdge));                           // R12

endmodule

// File: rtl/canBitTimer.sv
module canBitTimer
  import canBtPkg::*;
#(
  parameter int PRE_W = 8,
  parameter int T1_W  = 4,
  parameter int T2_W  = 3,
  localparam int REG_W = PRE_W + T1_W + T2_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgReq,
  output logic             cfgAck,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             rxIn,
  input  logic             busIdle,
  output logic             sampleStrike,
  output logic             bitEdge,
  output logic             rxBit
);

  btCtlT            ctl;
  logic             endOfBit;
  logic [REG_W-1:0] timingReg;

  assign rdData = timingReg;

  canBtCtl #(.PRE_W(PRE_W), .T1_W(T1_W), .T2_W(T2_W)) uCtl (
    .clk(clk), .rstN(rstN), .cfgReq(cfgReq), .wrEn(wrEn), .wrData(wrData),
    .rxIn(rxIn), .busIdle(busIdle), .endOfBit(endOfBit), .cfgAck(cfgAck),
    .timingReg(timingReg), .ctl(ctl)
  );

  canBtDp #(.PRE_W(PRE_W), .T1_W(T1_W), .T2_W(T2_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .preField(timingReg[PRE_W-1:0]),
    .t1Field(timingReg[PRE_W +: T1_W]),
    .t2Field(timingReg[PRE_W+T1_W +: T2_W]),
    .tripleEn(timingReg[REG_W-1]),
    .rxIn(rxIn), .endOfBit(endOfBit), .sampleStrike(sampleStrike),
    .bitEdge(bitEdge), .rxBit(rxBit)
  );

endmodule

// File: tb/sim_canBitTimer.sv
module sim_canBitTimer;

  logic        clk = 1'b0;
  logic        rstN, cfgReq, wrEn, rxIn, busIdle;
  logic [15:0] wrData;
  logic        cfgAck, sampleStrike, bitEdge, rxBit;
  logic [15:0] rdData;

  int nCmp = 0;
  int nBad = 0;
  bit rnd = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  canBitTimer u0 (
    .clk(clk), .rstN(rstN), .cfgReq(cfgReq), .cfgAck(cfgAck), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .rxIn(rxIn), .busIdle(busIdle),
    .sampleStrike(sampleStrike), .bitEdge(bitEdge), .rxBit(rxBit)
  );

  // behavioural reference model
  int mPre, mQ, mAck, mReg, mPrev, mH1, mH0, mRx, mSs, mBe, sinceHs;
  always @(posedge clk) begin
    if (!rstN) begin
      mPre = 0; mQ = 0; mAck = 0; mReg = 'h1300; mPrev = 1;
      mH1 = 1; mH0 = 1; mRx = 1; mSs = 0; mBe = 0; sinceHs = 1000;
    end else begin
      int p, t1, t2, tr, nq, hs, tk, run, endB, smp, ack, rg;
      p  = mReg & 'hFF;
      t1 = (mReg >> 8) & 'hF;
      t2 = (mReg >> 12) & 'h7;
      tr = (mReg >> 15) & 1;
      nq = t1 + t2 + 3;
      hs = (!mAck && busIdle && mPrev == 1 && rxIn == 0) ? 1 : 0;
      tk = (mPre == p) ? 1 : 0;
      run  = (!mAck && !hs && tk) ? 1 : 0;
      endB = (run && mQ == nq - 1) ? 1 : 0;
      smp  = (run && mQ == t1 + 1) ? 1 : 0;
      ack = mAck; rg = mReg;
      if (!mAck && cfgReq && endB) ack = 1;
      else if (mAck && !cfgReq) ack = 0;
      if (mAck && wrEn) rg = wrData;
      if (smp) mRx = tr ? (((mH1 + mH0 + rxIn) >= 2) ? 1 : 0) : rxIn;
      if (run) begin mH1 = mH0; mH0 = rxIn; end
      if (mAck || hs) begin mPre = 0; mQ = 0; end
      else if (tk) begin mPre = 0; mQ = (mQ == nq - 1) ? 0 : mQ + 1; end
      else mPre = mPre + 1;
      sinceHs = hs ? 0 : sinceHs + 1;
      mSs = smp; mBe = endB; mAck = ack; mReg = rg; mPrev = rxIn;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R6 cfgAck", cfgAck, mAck);
      chk(mAck ? "R8 rdData" : "R7 rdData", rdData, mReg);
      chk(mAck ? "R12 sampleStrike" : (sinceHs < 64 ? "R10 sampleStrike" : "R3 sampleStrike"),
          sampleStrike, mSs);
      chk(mAck ? "R12 bitEdge" : "R2 bitEdge", bitEdge, mBe);
      chk(mReg[15] ? "R5 rxBit" : "R4 rxBit", rxBit, mRx);
    end
    if (rnd) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rxIn = lfsr[0];
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enterCfg;
    cfgReq = 1'b1;
    for (int i = 0; i < 5000 && !cfgAck; i++) @(negedge clk);
    chk("R6 grant", cfgAck, 1);
  endtask

  task automatic wrReg(input logic [15:0] v);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic leaveAndTime(input int expSs);
    int n;
    cfgReq = 1'b0;
    @(negedge clk);
    chk("R9 release", cfgAck, 0);
    n = 0;
    while (!sampleStrike && n < 2000) begin @(negedge clk); n++; end
    chk("R9 first strike", n, expSs);
  endtask

  initial begin
    rstN = 0; cfgReq = 0; wrEn = 0; wrData = 0; rxIn = 1; busIdle = 0;
    cyc(3);
    chk("R11 rdData", rdData, 16'h1300);
    chk("R11 cfgAck", cfgAck, 0);
    chk("R11 sampleStrike", sampleStrike, 0);
    chk("R11 bitEdge", bitEdge, 0);
    chk("R11 rxBit", rxBit, 1);
    rstN = 1;
    rnd = 1;
    cyc(150);

    // locked write
    wrReg(16'hFFFF);
    chk("R7 locked", rdData, 16'h1300);

    // 10 quanta of 10 cycles, sample after quantum 8
    enterCfg();
    wrReg(16'h1609);
    chk("R8 written", rdData, 16'h1609);
    leaveAndTime(80);
    begin
      int n;
      while (!bitEdge) @(negedge clk);
      @(negedge clk); n = 1;
      while (!bitEdge && n < 1000) begin @(negedge clk); n++; end
      chk("R1 bit period", n, 100);
    end

    // triple sampling, prescaler 2, tseg1 3q, tseg2 3q
    enterCfg();
    wrReg(16'hA201);
    chk("R8 written", rdData, 16'hA201);
    leaveAndTime(8);
    cyc(400);

    // directed hard sync in mid bit
    rnd = 0; rxIn = 1; busIdle = 1;
    cyc(5);
    rxIn = 0;
    @(negedge clk);
    begin
      int n = 0;
      while (!sampleStrike && n < 1000) begin @(negedge clk); n++; end
      chk("R10 hard sync", n, 8);
    end

    // scattered hard syncs, then a request withdrawn before grant
    rnd = 1;
    cyc(400);
    busIdle = 0;
    cfgReq = 1; cyc(1); cfgReq = 0;
    cyc(50);

    // shortest bit: 3 quanta of 1 cycle
    enterCfg();
    wrReg(16'h0000);
    leaveAndTime(2);
    cyc(200);
    busIdle = 1;
    cyc(200);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule